// File: doc/BRIEF.md
# Permanent Fault Injection Wrapper

This block is placed inline on a 64-bit datapath signal, such as the output latch of an arithmetic unit, a register write bus or a computed address. While no fault is armed, every transfer passes through unchanged in the same cycle. A configuration pulse arms one permanent fault, described by a 2-bit fault model and a bit site. The fault can be a single bit stuck at 0 or at 1. It can also be a bridge between the bits at the site and the site plus one, in which the low value (AND) or the high value (OR) dominates.

Once armed, the fault corrupts every later transfer until reset or until another fault is armed in its place. Only one fault is present at a time. A sticky activation flag reports whether the fault has really changed a valid transfer. A fault that leaves every value it sees unchanged counts as masked and never raises the flag.

Top module: `fault_inject_wrap`

## Requirements
- R1: While no fault is armed, `out_data` equals `in_data` and `out_valid` equals `in_valid` in the same cycle.
- R2: With a stuck-at fault armed, model code 00 forces bit `site` of `out_data` to 0 and code 01 forces it to 1. All other bits equal `in_data`.
- R3: With model code 10 (dominant-0 bridge) armed, bits `site` and `site+1` of `out_data` both equal the AND of those two input bits. All other bits equal `in_data`.
- R4: With model code 11 (dominant-1 bridge) armed, bits `site` and `site+1` of `out_data` both equal the OR of those two input bits. All other bits equal `in_data`.
- R5: `arm`, `arm_model` and `arm_site` are sampled at a rising clock edge. An accepted request sets `fault_armed`, and its fault applies to every transfer from the next cycle until reset. An accepted request made while a fault is armed replaces that fault. Stuck-at faults accept any site from 0 to 63.
- R6: A bridge request (model 10 or 11) with site 63 is rejected. `fault_armed`, the armed fault and `out_data` stay exactly as they were before the request.
- R7: `fault_activated` rises after the first rising edge at which `in_valid` is high and `out_data` differs from `in_data`, and then stays high. Transfers that the fault does not change, and cycles with `in_valid` low, do not set it.
- R8: An accepted arm request clears `fault_activated` at the same edge. The transfer in that cycle is judged against the old fault and does not set the flag.
- R9: After reset, `fault_armed` and `fault_activated` are 0 and data passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Arm request, sampled at the rising edge |
| arm_model | input | 2 | Fault model: 00 stuck-0, 01 stuck-1, 10 dominant-0 bridge, 11 dominant-1 bridge |
| arm_site | input | 6 | Faulty bit, or low bit of the bridged pair |
| in_valid | input | 1 | Transfer present on `in_data` |
| in_data | input | 64 | Fault-free datapath value |
| out_valid | output | 1 | Copy of `in_valid` |
| out_data | output | 64 | Value after the armed fault is applied |
| fault_armed | output | 1 | A fault is in effect |
| fault_activated | output | 1 | Sticky: the armed fault has changed a valid transfer |

## Verification
Assertions check the following on every cycle. With nothing armed, data passes through untouched. Corruption stays within the one or two bits at the fault site. A stuck bit holds its constant, and the two bits of an armed bridge always match. A changed valid transfer raises the activation flag, and the flag stays high until a new arm. A rejected bridge request at the top bit leaves an unarmed wrapper unarmed. Some behaviour needs the bench's scenarios. These cover whether the AND or OR value is correct against a reference model, and masking on values where the fault is invisible. They also cover the replacement of one fault by another, and the rule that a rejected request leaves an existing fault untouched.

// File: rtl/fiw_pkg.sv
package fiw_pkg;

    typedef enum logic [1:0] {
        FM_STUCK0 = 2'b00,
        FM_STUCK1 = 2'b01,
        FM_DOM0   = 2'b10,
        FM_DOM1   = 2'b11
    } fault_model_e;

    function automatic logic is_bridge(input fault_model_e m);
        return m == FM_DOM0 || m == FM_DOM1;
    endfunction

endpackage

// File: rtl/fiw_cfg_reg.sv
module fiw_cfg_reg
    import fiw_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int SITE_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  fault_model_e      model_i,
    input  logic [SITE_W-1:0] site_i,
    output logic              accept_o,
    output logic              armed_o,
    output fault_model_e      model_o,
    output logic [SITE_W-1:0] site_o
);

    localparam logic [SITE_W-1:0] LAST_SITE = SITE_W'(DATA_W - 1);

    typedef struct packed {
        logic              armed;
        fault_model_e      model;
        logic [SITE_W-1:0] site;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic accept;

    always_comb begin
        accept = arm_i && !(is_bridge(model_i) && site_i == LAST_SITE);
        cfg_d  = cfg_q;
        if (accept) begin
            cfg_d.armed = 1'b1;
            cfg_d.model = model_i;
            cfg_d.site  = site_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{armed: 1'b0, model: FM_STUCK0, site: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign accept_o = accept;
    assign armed_o  = cfg_q.armed;
    assign model_o  = cfg_q.model;
    assign site_o   = cfg_q.site;

    AST_REJECT_TOP_BRIDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && is_bridge(model_i) && site_i == LAST_SITE && !armed_o) |=> !armed_o); // R6

    AST_ARMED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> armed_o); // R5

endmodule

// File: rtl/fiw_corrupt.sv
module fiw_corrupt
    import fiw_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int SITE_W = $clog2(DATA_W)
) (
    input  logic              armed_i,
    input  fault_model_e      model_i,
    input  logic [SITE_W-1:0] site_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);

    logic bridge;
    assign bridge = is_bridge(model_i);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic lo_sel;
        logic hi_sel;
        logic up_nb;
        logic dn_nb;

        assign lo_sel = armed_i && site_i == SITE_W'(i);

        if (i == 0) begin : g_first
            assign hi_sel = 1'b0;
            assign dn_nb  = data_i[i];
        end else begin : g_rest
            assign hi_sel = armed_i && bridge && site_i == SITE_W'(i - 1);
            assign dn_nb  = data_i[i-1];
        end

        if (i == DATA_W - 1) begin : g_last
            assign up_nb = data_i[i];
        end else begin : g_inner
            assign up_nb = data_i[i+1];
        end

        always_comb begin
            data_o[i] = data_i[i];
            if (lo_sel) begin
                unique case (model_i)
                    FM_STUCK0: data_o[i] = 1'b0;
                    FM_STUCK1: data_o[i] = 1'b1;
                    FM_DOM0:   data_o[i] = data_i[i] & up_nb;
                    FM_DOM1:   data_o[i] = data_i[i] | up_nb;
                    default:   data_o[i] = data_i[i];
                endcase
            end else if (hi_sel) begin
                data_o[i] = (model_i == FM_DOM0) ? (data_i[i] & dn_nb)
                                                 : (data_i[i] | dn_nb);
            end
        end
    end

endmodule

// File: rtl/fiw_activation.sv
module fiw_activation (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic valid_i,
    input  logic diff_i,
    output logic hit_o
);

    typedef struct packed {
        logic hit;
    } act_t;

    act_t act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (clear_i) begin
            act_d.hit = 1'b0;
        end else if (valid_i && diff_i) begin
            act_d.hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '{hit: 1'b0};
        end else begin
            act_q <= act_d;
        end
    end

    assign hit_o = act_q.hit;

    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !clear_i) |=> hit_o); // R7

    AST_HIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !hit_o); // R8

endmodule

// File: rtl/fault_inject_wrap.sv
module fault_inject_wrap
    import fiw_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int SITE_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [1:0]        arm_model,
    input  logic [SITE_W-1:0] arm_site,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              fault_armed,
    output logic              fault_activated
);

    logic              accept;
    logic              armed;
    fault_model_e      model_q;
    logic [SITE_W-1:0] site_q;
    logic              differs;

    fiw_cfg_reg #(.DATA_W(DATA_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm),
        .model_i  (fault_model_e'(arm_model)),
        .site_i   (arm_site),
        .accept_o (accept),
        .armed_o  (armed),
        .model_o  (model_q),
        .site_o   (site_q)
    );

    fiw_corrupt #(.DATA_W(DATA_W)) i_corrupt (
        .armed_i (armed),
        .model_i (model_q),
        .site_i  (site_q),
        .data_i  (in_data),
        .data_o  (out_data)
    );

    assign differs = out_data != in_data;

    fiw_activation i_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .valid_i (in_valid),
        .diff_i  (differs),
        .hit_o   (fault_activated)
    );

    assign out_valid   = in_valid;
    assign fault_armed = armed;

    logic [DATA_W-1:0] site_mask;
    logic [SITE_W:0]   site_up;
    always_comb begin
        site_mask = DATA_W'(1) << site_q;
        if (is_bridge(model_q)) begin
            site_mask = site_mask | (DATA_W'(2) << site_q);
        end
        site_up = {1'b0, site_q} + 1'b1;
    end

    AST_PASS_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_armed |-> out_data == in_data); // R1

    AST_SITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_armed |-> ((out_data ^ in_data) & ~site_mask) == '0); // R2

    AST_STUCK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_armed && !is_bridge(model_q)) |-> out_data[site_q] == model_q[0]); // R2

    AST_BRIDGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_armed && is_bridge(model_q) && site_up < (SITE_W+1)'(DATA_W))
            |-> out_data[site_q] == out_data[site_up[SITE_W-1:0]]); // R3

    AST_HIT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_data != in_data && !accept) |=> fault_activated); // R7

endmodule

// File: tb/test_fault_inject_wrap.sv
module test_fault_inject_wrap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic [1:0]  arm_model = 2'b00;
    logic [5:0]  arm_site = 6'd0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        fault_armed;
    logic        fault_activated;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic       e_armed = 0;
    logic [1:0] e_model = 0;
    int         e_site  = 0;
    logic       e_hit   = 0;

    fault_inject_wrap i_fault_inject_wrap (
        .clk(clk), .rst_n(rst_n), .arm(arm), .arm_model(arm_model),
        .arm_site(arm_site), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .fault_armed(fault_armed), .fault_activated(fault_activated)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cycles++;

    function automatic logic [63:0] ref_out(logic [63:0] d, logic a, logic [1:0] m, int s);
        logic [63:0] r = d;
        logic t;
        if (!a) return d;
        case (m)
            2'b00: r[s] = 1'b0;
            2'b01: r[s] = 1'b1;
            2'b10: begin t = d[s] & d[s+1]; r[s] = t; r[s+1] = t; end
            default: begin t = d[s] | d[s+1]; r[s] = t; r[s+1] = t; end
        endcase
        return r;
    endfunction

    function automatic string data_tag(logic a, logic [1:0] m);
        if (!a) return "R1";
        case (m)
            2'b00, 2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(logic a, logic [1:0] m, int s, logic v, logic [63:0] d,
                        string arm_req = "R5");
        logic [63:0] exp;
        logic acc;
        @(negedge clk);
        arm = a; arm_model = m; arm_site = 6'(s); in_valid = v; in_data = d;
        #1;
        exp = ref_out(d, e_armed, e_model, e_site);
        check64(data_tag(e_armed, e_model), out_data, exp);
        check1("R1", out_valid, v);
        check1(arm_req, fault_armed, e_armed);
        check1(e_armed ? "R7" : "R8", fault_activated, e_hit);
        @(posedge clk);
        acc = a && !(m[1] && s == 63);
        if (acc) begin
            e_armed = 1; e_model = m; e_site = s; e_hit = 0;
        end else if (v && exp != d) begin
            e_hit = 1;
        end
    endtask

    function automatic logic [63:0] rnd64();
        case ($urandom % 4)
            0: return '0;
            1: return '1;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        #25;
        #1;
        check1("R9", fault_armed, 1'b0);
        check1("R9", fault_activated, 1'b0);
        rst_n = 1'b1;
        // R9 / R1: pass-through out of reset
        step(0, 0, 0, 1, 64'hDEAD_BEEF_0123_4567, "R9");
        step(0, 0, 0, 1, '1, "R9");
        // R6: bridge at top bit rejected from unarmed
        step(1, 2'b11, 63, 1, 64'h0F0F, "R6");
        step(0, 0, 0, 1, 64'h8000_0000_0000_0001, "R6");
        step(1, 2'b10, 63, 0, 0, "R6");
        step(0, 0, 0, 1, '1, "R6");
        // R7: stuck-0 on bit 5, masked while bit is 0
        step(1, 2'b00, 5, 1, 64'h20);
        step(0, 0, 0, 1, 64'h0);
        step(0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFDF);
        step(0, 0, 0, 0, 64'h20);
        step(0, 0, 0, 1, 64'h1F);
        step(0, 0, 0, 1, 64'h20);   // activates
        step(0, 0, 0, 1, 64'h0);    // sticky
        // R6: rejected bridge keeps existing stuck-0
        step(1, 2'b11, 63, 1, 64'h20, "R6");
        step(0, 0, 0, 1, 64'h20, "R6");
        // R8/R5: re-arm dominant-0 at 62 clears flag
        step(1, 2'b10, 62, 1, 64'h20);
        step(0, 0, 0, 1, 64'hC000_0000_0000_0000);
        step(0, 0, 0, 1, 64'h4000_0000_0000_0000);
        step(0, 0, 0, 1, 64'h8000_0000_0000_0000);
        // R4: dominant-1 at 0
        step(1, 2'b11, 0, 0, 0);
        step(0, 0, 0, 1, 64'h1);
        step(0, 0, 0, 1, 64'h2);
        // R2: stuck-1 at 63 accepted
        step(1, 2'b01, 63, 1, 64'h0);
        step(0, 0, 0, 1, 64'h0);
        step(0, 0, 0, 1, '1);
        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic a = ($urandom % 40) == 0;
            logic [1:0] m = 2'($urandom);
            int s = ($urandom % 8 == 0) ? 63 : int'($urandom % 64);
            step(a, m, s, ($urandom % 4) != 0, rnd64());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule